// File: doc/BRIEF.md
# Shared Iterative Multiply/Divide Unit

This block computes 32-bit multiplies and divides, signed or unsigned, one bit per clock. A single 64-bit working register holds the operation from start to finish, and one adder serves both kinds of operation. For a multiply, the adder does the add-and-shift-right step. For a divide, it does the trial subtraction of the restoring method, which shifts left.

A caller raises `start` for one cycle while the unit is idle. That cycle also presents the opcode and both operands. The unit then stays busy for a fixed 34 cycles: one setup cycle, 32 step cycles and one sign-correction cycle. After that it pulses `done`. The result then sits on `hiOut` and `loOut` until the next operation is accepted.

Overflow is not checked. A zero divisor is not trapped either, and software is expected to screen for both. A division by zero still completes in the normal time with a fixed, known result.

Top module: `iter_muldiv`

## Requirements
- R1: After reset `busy`, `done`, `hiOut` and `loOut` are all zero.
- R2: `op` selects the operation. Bit 1 set means divide and clear means multiply. Bit 0 set means the operands are two's complement and clear means unsigned. So 00 is unsigned multiply, 01 signed multiply, 10 unsigned divide and 11 signed divide.
- R3: An unsigned multiply returns the full 64-bit product of `opA` and `opB`, with the upper 32 bits on `hiOut` and the lower 32 bits on `loOut`.
- R4: A signed multiply returns the full 64-bit two's complement product split the same way, including the case where both operands are the most negative value.
- R5: An unsigned divide places the quotient `opA / opB` on `loOut` and the remainder on `hiOut`.
- R6: A signed divide rounds the quotient toward zero. The quotient is negative when the operand signs differ, and the remainder carries the sign of the dividend. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R7: A divide by zero takes the normal time. It gives a remainder equal to the dividend. The quotient is all ones, except for a signed divide of a negative dividend, where it is 1 (all ones, negated).
- R8: `busy` rises in the cycle after a `start` is accepted and stays high for exactly 34 cycles. `done` is high for exactly one cycle: the first cycle in which `busy` is low again.
- R9: `start` is ignored while `busy` is high. The running operation and its result are not disturbed.
- R10: `hiOut` and `loOut` hold their value while the unit is idle and no `start` is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 2 | Operation select: bit 1 = divide, bit 0 = signed |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hiOut | output | 32 | Product upper half, or remainder |
| loOut | output | 32 | Product lower half, or quotient |

## Verification
The assertions assume that `start`, `op`, `opA` and `opB` are free of X while reset is released. They also assume the partial-remainder bound is checked only when the divisor is nonzero, since a zero divisor leaves the remainder unbounded by design.

The stimulus drives inputs only at the falling edge. It holds `start` for exactly one cycle per operation and waits for `done` before issuing the next one. The one exception is a deliberate `start` pulse placed mid-operation to exercise the ignore rule. Random operands are skewed toward sign-bit, zero and small-divisor values, so every sign combination and the divide-by-zero path occur.

// File: rtl/iter_muldiv_pkg.sv
package iter_muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } mdOp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ITER,
    ST_FIX
  } mdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture raw operands and opcode
    logic setup;  // take magnitudes, arrange working register
    logic step;   // one shift-add or shift-subtract iteration
    logic fix;    // apply result signs
  } mdStrobe_t;

endpackage

// File: rtl/iter_muldiv_ctrl.sv
module iter_muldiv_ctrl
  import iter_muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output mdStrobe_t strb,
  output logic      busy,
  output logic      done
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  mdState_e         state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == ST_FIX);
      unique case (state)
        ST_IDLE:  if (start) state <= ST_SETUP;
        ST_SETUP: begin
          state   <= ST_ITER;
          stepCnt <= '0;
        end
        ST_ITER: begin
          stepCnt <= stepCnt + CNT_W'(1);
          if (stepCnt == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load  = (state == ST_IDLE) && start;
    strb.setup = (state == ST_SETUP);
    strb.step  = (state == ST_ITER);
    strb.fix   = (state == ST_FIX);
    busy       = (state != ST_IDLE);
  end

  // R8: completion pulse lands only once the unit is idle again
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: done never lasts more than one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: sign-correction cycle is followed by the done pulse
  assert_fix_then_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIX) |=> done);

  // R9: busy only rises because of a start seen while idle
  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R8: iterations run uninterrupted until the last step
  assert_iter_continues_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ITER && stepCnt != LAST_STEP) |=> (state == ST_ITER));

endmodule

// File: rtl/iter_muldiv_dp.sv
module iter_muldiv_dp
  import iter_muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrobe_t        strb,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);
  localparam int W2 = 2 * WIDTH;

  logic [W2-1:0]    work;    // {hi, lo}
  logic [WIDTH-1:0] opnd;    // multiplicand or divisor magnitude
  logic             isDiv, isSigned, negLo, negHi;

  // operand magnitudes taken from the raw values parked in work
  logic [WIDTH-1:0] rawA, rawB, magA, magB;
  always_comb begin
    rawA = work[W2-1:WIDTH];
    rawB = work[WIDTH-1:0];
    magA = (isSigned && rawA[WIDTH-1]) ? -rawA : rawA;
    magB = (isSigned && rawB[WIDTH-1]) ? -rawB : rawB;
  end

  // the one shared adder
  logic [WIDTH:0]   addA, addB;
  logic             addCin;
  logic [WIDTH+1:0] addSum;
  always_comb begin
    if (isDiv) begin
      addA   = work[W2-1:WIDTH-1];
      addB   = ~{1'b0, opnd};
      addCin = 1'b1;
    end else begin
      addA   = {1'b0, work[W2-1:WIDTH]};
      addB   = work[0] ? {1'b0, opnd} : '0;
      addCin = 1'b0;
    end
    addSum = {1'b0, addA} + {1'b0, addB} + (WIDTH + 2)'(addCin);
  end

  logic             fits;
  logic [W2-1:0]    stepNext;
  always_comb begin
    fits = addSum[WIDTH+1];
    if (isDiv)
      stepNext = {(fits ? addSum[WIDTH-1:0] : work[W2-2:WIDTH-1]),
                  work[WIDTH-2:0], fits};
    else
      stepNext = {addSum[WIDTH:0], work[WIDTH-1:1]};
  end

  logic [W2-1:0] fixNext;
  always_comb begin
    if (isDiv)
      fixNext = {(negHi ? -work[W2-1:WIDTH] : work[W2-1:WIDTH]),
                 (negLo ? -work[WIDTH-1:0] : work[WIDTH-1:0])};
    else
      fixNext = negLo ? -work : work;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work     <= '0;
      opnd     <= '0;
      isDiv    <= 1'b0;
      isSigned <= 1'b0;
      negLo    <= 1'b0;
      negHi    <= 1'b0;
    end else if (strb.load) begin
      work     <= {opA, opB};
      isDiv    <= op[1];
      isSigned <= op[0];
    end else if (strb.setup) begin
      opnd  <= isDiv ? magB : magA;
      work  <= {{WIDTH{1'b0}}, (isDiv ? magA : magB)};
      negLo <= isSigned && (rawA[WIDTH-1] ^ rawB[WIDTH-1]);
      negHi <= isSigned && rawA[WIDTH-1];
    end else if (strb.step) begin
      work <= stepNext;
    end else if (strb.fix) begin
      work <= fixNext;
    end
  end

  assign hiOut = work[W2-1:WIDTH];
  assign loOut = work[WIDTH-1:0];

  // R5: restoring divide keeps the partial remainder below the divisor
  assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.step) && isDiv && (opnd != '0)) |-> (work[W2-1:WIDTH] < opnd));

endmodule

// File: rtl/iter_muldiv.sv
module iter_muldiv
  import iter_muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);
  mdStrobe_t strb;

  iter_muldiv_ctrl #(.WIDTH(WIDTH)) ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strb(strb), .busy(busy), .done(done)
  );

  iter_muldiv_dp #(.WIDTH(WIDTH)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .op(op),
    .opA(opA), .opB(opB), .hiOut(hiOut), .loOut(loOut)
  );

  // R10: results hold while idle with no start
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && !$past(start)) |-> ($stable(hiOut) && $stable(loOut)));

endmodule

// File: tb/iter_muldiv_test.sv
module iter_muldiv_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opA = '0, opB = '0;
  logic        busy, done;
  logic [31:0] hiOut, loOut;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2 clk = ~clk;  // 250 MHz

  iter_muldiv #(.WIDTH(32)) uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .hiOut(hiOut), .loOut(loOut)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {hi,lo} from the requirement text
  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a,
                                        input logic [31:0] b);
    logic sgn, neg;
    logic [31:0] ua, ub, q, r;
    logic [63:0] p;
    sgn = o[0];
    ua  = (sgn && a[31]) ? -a : a;
    ub  = (sgn && b[31]) ? -b : b;
    neg = sgn && (a[31] ^ b[31]);
    if (!o[1]) begin
      p = {32'd0, ua} * {32'd0, ub};
      if (neg) p = -p;
      return p;
    end
    if (ub == 0) begin
      q = '1;
      r = ua;
    end else begin
      q = ua / ub;
      r = ua % ub;
    end
    if (neg) q = -q;
    if (sgn && a[31]) r = -r;
    return {r, q};
  endfunction

  function automatic string reqOf(input logic [1:0] o);
    case (o)
      2'b00:   return "R2/R3 mulu";
      2'b01:   return "R2/R4 muls";
      2'b10:   return "R2/R5 divu";
      default: return "R2/R6 divs";
    endcase
  endfunction

  // run one operation; optionally poke start mid-way (R9)
  task automatic runOp(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                       input bit poke, input string req);
    int busyCycles;
    logic [63:0] exp;
    exp = model(o, a, b);
    @(negedge clk);
    start = 1'b1; op = o; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0; opA = ~a; opB = b + 32'd3; op = ~o;
    busyCycles = 0;
    for (int guard = 0; guard < 100 && !done; guard++) begin
      if (busy) busyCycles++;
      if (poke && busyCycles == 10) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(done === 1'b1 && busy === 1'b0, "R8 done with busy low", {62'd0, busy, done}, 64'd1);
    check(busyCycles == 34, "R8 busy length", 64'(busyCycles), 64'd34);
    check({hiOut, loOut} === exp, poke ? "R9 start ignored" : req, {hiOut, loOut}, exp);
    @(negedge clk);
    check(done === 1'b0, "R8 done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check({busy, done, hiOut, loOut} === 66'd0, "R1 reset state",
          {hiOut, loOut}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3 max unsigned product");
    runOp(2'b00, 32'd12345, 32'd0, 1'b0, "R3 times zero");
    runOp(2'b01, 32'hFFFF_FFFF, 32'd1, 1'b0, "R4 -1*1");
    runOp(2'b01, 32'h8000_0000, 32'h8000_0000, 1'b0, "R4 min*min");
    runOp(2'b01, 32'hFFFF_FFF9, 32'd6, 1'b0, "R4 -7*6");
    runOp(2'b10, 32'd100, 32'd7, 1'b0, "R5 100/7");
    runOp(2'b10, 32'd5, 32'd9, 1'b0, "R5 small dividend");
    runOp(2'b11, 32'hFFFF_FFF9, 32'd2, 1'b0, "R6 -7/2");
    runOp(2'b11, 32'd7, 32'hFFFF_FFFE, 1'b0, "R6 7/-2");
    runOp(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R6 min/-1");
    runOp(2'b10, 32'hDEAD_BEEF, 32'd0, 1'b0, "R7 unsigned div by zero");
    runOp(2'b11, 32'hFFFF_FFFB, 32'd0, 1'b0, "R7 signed negative div by zero");
    runOp(2'b11, 32'd42, 32'd0, 1'b0, "R7 signed positive div by zero");
    runOp(2'b00, 32'd1000, 32'd3000, 1'b1, "R9");
    runOp(2'b11, 32'hFFFF_0000, 32'd77, 1'b1, "R9");

    // R10: output hold while idle
    held = {hiOut, loOut};
    opA = 32'h1234_5678; opB = 32'h9;
    repeat (6) @(negedge clk);
    check({hiOut, loOut} === held, "R10 hold while idle", {hiOut, loOut}, held);

    for (int i = 0; i < 200; i++) begin
      logic [1:0]  o;
      logic [31:0] a, b;
      o = 2'($urandom);
      a = $urandom;
      b = $urandom;
      case ($urandom % 6)
        0: b = b % 16;
        1: a = {1'b1, 31'($urandom % 8)};
        2: b = 32'hFFFF_FFFF;
        default: ;
      endcase
      runOp(o, a, b, 1'b0, reqOf(o));
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule